// File: doc/BRIEF.md
# Round-Robin Lane Distributor with Alignment Rows

This block takes a single stream of 68-bit blocks, each a 64-bit payload and a 4-bit type code, and deals them out one per cycle across a group of parallel output lanes in round-robin order. The group is either 4 or 10 lanes wide, chosen by a select input. It is meant to sit between a reconciliation layer and a set of per-lane coding paths, so that each lane carries an equal share of the traffic.

On request it emits an alignment row: every active lane carries an alignment block in the same output cycle, and the round-robin sequence restarts at lane 0 afterwards. A receiver can use these rows to remove the skew between lanes. A per-lane fault mask removes lanes from the deal: a faulty lane receives no data blocks, carries a null block in every other cycle, and still carries its share of each alignment row.

Top module: `lane_distributor`

## Requirements
- R1: While reset is high and in the first cycle after it, every lane valid bit is low.
- R2: With the 4-lane select (`wide_mode`=0) and no faults, the k-th accepted block after an alignment row or reset appears on lane k mod 4, with its 64-bit payload and 4-bit type unchanged.
- R3: With the 10-lane select (`wide_mode`=1) and no faults, the k-th accepted block appears on lane k mod 10; if the lane count changes while the next lane index is at or beyond the new count, dealing restarts at lane 0.
- R4: Lanes whose index is at or beyond the selected lane count never assert valid.
- R5: One cycle after `align_req` is high, every active lane is valid with type 1100 and payload A5 repeated in every byte, including faulty lanes.
- R6: While `align_req` is high, `in_ready` is low and no input block is taken.
- R7: The first block accepted after an alignment row goes to the lowest-numbered healthy active lane.
- R8: In every output cycle that is not an alignment row, each faulty active lane is valid with a null block: type 1101 and an all-zero payload.
- R9: Data blocks skip faulty lanes: each block goes to the next healthy active lane in cyclic order after the lane that took the previous block.
- R10: Type codes pass through untouched, among them 0000 (data), 1111 (all control), 1001 (start in byte 0), 1010 (start in byte 4) and terminate codes 1000 down to 0001 for a terminate in byte 0 to 7.
- R11: An accepted block appears on exactly one lane one clock after the edge that accepts it; a healthy lane that receives nothing in a cycle is not valid.
- R12: When every active lane is faulty, `in_ready` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input block present |
| in_data | input | 64 | Input block payload |
| in_ctrl | input | 4 | Input block type code |
| in_ready | output | 1 | Block taken on this edge when in_valid is high |
| wide_mode | input | 1 | 0 selects 4 lanes, 1 selects 10 lanes |
| align_req | input | 1 | Emit an alignment row next cycle |
| fault_mask | input | 10 | Per-lane fault flags, bit i for lane i |
| lane_valid | output | 10 | Per-lane block valid |
| lane_data | output | 640 | Lane i payload at bits 64*i+63 down to 64*i |
| lane_ctrl | output | 40 | Lane i type at bits 4*i+3 down to 4*i |

## Verification
`in_ready` is a same-cycle function of `align_req`, the mask and the lane count, so the bench checks it one time step after it drives those inputs, before the clock edge. Lane outputs are registered once, so the row produced by the inputs of one cycle is due right after the next rising edge; the bench computes that row from its own copy of the dealing order and compares every lane a short delay after that edge, before any input changes again.

// File: rtl/lane_dist_pkg.sv
package lane_dist_pkg;
  localparam int DATA_W = 64;
  localparam int CTRL_W = 4;
  localparam logic [CTRL_W-1:0] TYPE_ALIGN = 4'b1100;
  localparam logic [CTRL_W-1:0] TYPE_NULL  = 4'b1101;
  localparam logic [DATA_W-1:0] ALIGN_PAYLOAD = {(DATA_W/8){8'hA5}};
endpackage

// File: rtl/lane_rr_pick.sv
module lane_rr_pick #(
  parameter int LANES = 10,
  parameter int IDX_W = $clog2(LANES)
) (
  input  logic [IDX_W-1:0] start,
  input  logic [IDX_W:0]   n_act,
  input  logic [LANES-1:0] healthy,
  output logic [IDX_W-1:0] sel,
  output logic             found
);
  logic [IDX_W:0] cand;

  // First healthy lane at or after start, wrapping inside the active count.
  always_comb begin
    found = 1'b0;
    sel   = '0;
    cand  = '0;
    for (int k = 0; k < LANES; k++) begin
      cand = {1'b0, start} + (IDX_W+1)'(k);
      if (cand >= n_act) cand = cand - n_act;
      if (!found && ((IDX_W+1)'(k) < n_act) && (cand < (IDX_W+1)'(LANES))) begin
        if (healthy[cand[IDX_W-1:0]]) begin
          found = 1'b1;
          sel   = cand[IDX_W-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/lane_slot_reg.sv
module lane_slot_reg
  import lane_dist_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              faulty,
  input  logic              load_align,
  input  logic              load_data,
  input  logic [DATA_W-1:0] blk_data,
  input  logic [CTRL_W-1:0] blk_ctrl,
  output logic              q_valid,
  output logic [DATA_W-1:0] q_data,
  output logic [CTRL_W-1:0] q_ctrl
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
      q_data  <= '0;
      q_ctrl  <= '0;
    end else if (load_align && active) begin
      q_valid <= 1'b1;
      q_data  <= ALIGN_PAYLOAD;
      q_ctrl  <= TYPE_ALIGN;
    end else if (load_data) begin
      q_valid <= 1'b1;
      q_data  <= blk_data;
      q_ctrl  <= blk_ctrl;
    end else if (faulty && active) begin
      q_valid <= 1'b1;
      q_data  <= '0;
      q_ctrl  <= TYPE_NULL;
    end else begin
      q_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/lane_distributor.sv
module lane_distributor
  import lane_dist_pkg::*;
#(
  parameter int MAX_LANES    = 10,
  parameter int NARROW_LANES = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_valid,
  input  logic [DATA_W-1:0]           in_data,
  input  logic [CTRL_W-1:0]           in_ctrl,
  output logic                        in_ready,
  input  logic                        wide_mode,
  input  logic                        align_req,
  input  logic [MAX_LANES-1:0]        fault_mask,
  output logic [MAX_LANES-1:0]        lane_valid,
  output logic [MAX_LANES*DATA_W-1:0] lane_data,
  output logic [MAX_LANES*CTRL_W-1:0] lane_ctrl
);
  localparam int IDX_W = $clog2(MAX_LANES);

  logic [IDX_W:0]         n_act;
  logic [MAX_LANES-1:0]   active;
  logic [MAX_LANES-1:0]   healthy;
  logic [IDX_W-1:0]       ptr_q;
  logic [IDX_W-1:0]       start;
  logic [IDX_W-1:0]       sel;
  logic [IDX_W:0]         sel_inc;
  logic                   found;
  logic                   accept;

  assign n_act = wide_mode ? (IDX_W+1)'(MAX_LANES) : (IDX_W+1)'(NARROW_LANES);

  genvar g;
  generate
    for (g = 0; g < MAX_LANES; g++) begin : g_mask
      assign active[g] = ((IDX_W+1)'(g) < n_act);
    end
  endgenerate

  assign healthy  = active & ~fault_mask;
  assign in_ready = ~align_req & (|healthy);
  assign accept   = in_valid & in_ready;
  assign start    = ({1'b0, ptr_q} >= n_act) ? '0 : ptr_q;

  lane_rr_pick #(.LANES(MAX_LANES), .IDX_W(IDX_W)) u_pick (
    .start   (start),
    .n_act   (n_act),
    .healthy (healthy),
    .sel     (sel),
    .found   (found)
  );

  assign sel_inc = {1'b0, sel} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || align_req) begin
      ptr_q <= '0;
    end else if (accept && found) begin
      ptr_q <= (sel_inc >= n_act) ? '0 : sel_inc[IDX_W-1:0];
    end
  end

  generate
    for (g = 0; g < MAX_LANES; g++) begin : g_lane
      lane_slot_reg u_slot (
        .clk        (clk),
        .rst        (rst),
        .active     (active[g]),
        .faulty     (fault_mask[g]),
        .load_align (align_req),
        .load_data  (accept && found && (sel == IDX_W'(g))),
        .blk_data   (in_data),
        .blk_ctrl   (in_ctrl),
        .q_valid    (lane_valid[g]),
        .q_data     (lane_data[g*DATA_W +: DATA_W]),
        .q_ctrl     (lane_ctrl[g*CTRL_W +: CTRL_W])
      );
    end
  endgenerate
endmodule

// File: rtl/lane_distributor_chk.sv
module lane_distributor_chk
  import lane_dist_pkg::*;
#(
  parameter int MAX_LANES    = 10,
  parameter int NARROW_LANES = 4
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        in_valid,
  input logic                        in_ready,
  input logic                        wide_mode,
  input logic                        align_req,
  input logic [MAX_LANES-1:0]        fault_mask,
  input logic [MAX_LANES-1:0]        lane_valid,
  input logic [MAX_LANES*CTRL_W-1:0] lane_ctrl
);
  logic [MAX_LANES-1:0] carries_data;
  logic [MAX_LANES-1:0] healthy_now;

  genvar g;
  generate
    for (g = 0; g < MAX_LANES; g++) begin : g_cls
      assign carries_data[g] = lane_valid[g] &&
                               (lane_ctrl[g*CTRL_W +: CTRL_W] != TYPE_ALIGN) &&
                               (lane_ctrl[g*CTRL_W +: CTRL_W] != TYPE_NULL);
      assign healthy_now[g] = ~fault_mask[g] && (wide_mode || (g < NARROW_LANES));
    end
  endgenerate

  // R6
  p_ready_low_r6: assert property (@(posedge clk) disable iff (rst)
    align_req |-> !in_ready);

  // R12
  p_no_dest_r12: assert property (@(posedge clk) disable iff (rst)
    (healthy_now == '0) |-> !in_ready);

  // R4
  p_beyond_idle_r4: assert property (@(posedge clk) disable iff (rst)
    (!align_req && !wide_mode) |=> (lane_valid[MAX_LANES-1:NARROW_LANES] == '0));

  // R5
  p_align_row_r5: assert property (@(posedge clk) disable iff (rst)
    (align_req && !wide_mode) |=> (lane_valid[NARROW_LANES-1:0] == '1) &&
                                  (lane_ctrl[CTRL_W-1:0] == TYPE_ALIGN));

  // R11
  p_single_lane_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot0(carries_data));

  // R11
  p_accept_shows_r11: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> ($countones(carries_data) == 1));
endmodule

bind lane_distributor lane_distributor_chk #(
  .MAX_LANES(MAX_LANES), .NARROW_LANES(NARROW_LANES)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .wide_mode(wide_mode), .align_req(align_req), .fault_mask(fault_mask),
  .lane_valid(lane_valid), .lane_ctrl(lane_ctrl)
);

// File: tb/lane_distributor_tb.sv
`timescale 1ns/100ps
module lane_distributor_tb;
  localparam int L  = 10;
  localparam int DW = 64;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst;
  logic          in_valid;
  logic [DW-1:0] in_data;
  logic [CW-1:0] in_ctrl;
  logic          in_ready;
  logic          wide_mode;
  logic          align_req;
  logic [L-1:0]  fault_mask;
  logic [L-1:0]  lane_valid;
  logic [L*DW-1:0] lane_data;
  logic [L*CW-1:0] lane_ctrl;

  int checks = 0;
  int fails  = 0;
  int ptr    = 0;
  bit finished = 0;

  logic [L-1:0]    e_valid;
  logic [L*DW-1:0] e_data;
  logic [L*CW-1:0] e_ctrl;

  always #2.5 clk = ~clk;

  lane_distributor u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_ctrl(in_ctrl), .in_ready(in_ready), .wide_mode(wide_mode),
    .align_req(align_req), .fault_mask(fault_mask), .lane_valid(lane_valid),
    .lane_data(lane_data), .lane_ctrl(lane_ctrl)
  );

  function automatic logic [CW-1:0] legal_code(int pick);
    case (pick % 12)
      0: return 4'b0000;
      1: return 4'b1111;
      2: return 4'b1001;
      3: return 4'b1010;
      default: return 4'(8 - ((pick % 12) - 4));
    endcase
  endfunction

  function automatic int next_lane(int from, int n, logic [L-1:0] fm);
    int s = (from >= n) ? 0 : from;
    for (int k = 0; k < n; k++) begin
      int c = (s + k) % n;
      if (!fm[c]) return c;
    end
    return -1;
  endfunction

  task automatic check(bit ok, string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(string req, bit v, logic [DW-1:0] d, logic [CW-1:0] c,
                      bit wide, bit al, logic [L-1:0] fm);
    int n;
    int sel;
    logic [L-1:0] fmn;
    bit exp_rdy;
    @(negedge clk);
    in_valid = v; in_data = d; in_ctrl = c;
    wide_mode = wide; align_req = al; fault_mask = fm;
    #1;
    n = wide ? 10 : 4;
    fmn = fm;
    sel = next_lane(ptr, n, fmn);
    exp_rdy = !al && (sel >= 0);
    check(in_ready == exp_rdy, al ? "R6" : (sel < 0 ? "R12" : req), "in_ready",
          DW'(in_ready), DW'(exp_rdy));
    e_valid = '0; e_data = '0; e_ctrl = '0;
    if (al) begin
      for (int i = 0; i < n; i++) begin
        e_valid[i] = 1'b1;
        e_data[i*DW +: DW] = {8{8'hA5}};
        e_ctrl[i*CW +: CW] = 4'b1100;
      end
      ptr = 0;
    end else begin
      if (v && exp_rdy) begin
        e_valid[sel] = 1'b1;
        e_data[sel*DW +: DW] = d;
        e_ctrl[sel*CW +: CW] = c;
        ptr = (sel + 1) % n;
      end
      for (int i = 0; i < n; i++)
        if (fm[i]) begin
          e_valid[i] = 1'b1;
          e_ctrl[i*CW +: CW] = 4'b1101;
        end
    end
    @(posedge clk);
    #1;
    for (int i = 0; i < L; i++) begin
      string r;
      r = (i >= n) ? "R4" : (al ? "R5" : (fm[i] ? "R8" : req));
      check(lane_valid[i] == e_valid[i], r, $sformatf("lane %0d valid", i),
            DW'(lane_valid[i]), DW'(e_valid[i]));
      if (e_valid[i]) begin
        check(lane_data[i*DW +: DW] == e_data[i*DW +: DW], r,
              $sformatf("lane %0d data", i), lane_data[i*DW +: DW], e_data[i*DW +: DW]);
        check(lane_ctrl[i*CW +: CW] == e_ctrl[i*CW +: CW], r == req ? "R10" : r,
              $sformatf("lane %0d type", i), DW'(lane_ctrl[i*CW +: CW]), DW'(e_ctrl[i*CW +: CW]));
      end
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] rd;
    void'($urandom(32'd1357));
    rst = 1'b1; in_valid = 0; in_data = '0; in_ctrl = '0;
    wide_mode = 0; align_req = 0; fault_mask = '0;
    repeat (3) @(posedge clk);
    #1;
    check(lane_valid == '0, "R1", "valid in reset", DW'(lane_valid), '0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    check(lane_valid == '0, "R1", "valid after reset", DW'(lane_valid), '0);
    ptr = 0;

    // R2: 4-lane dealing, every legal type code (R10)
    for (int k = 0; k < 12; k++)
      step("R2", 1, 64'h1111_0000_0000_0000 + 64'(k), legal_code(k), 0, 0, '0);
    // R11: idle cycle leaves healthy lanes quiet
    step("R11", 0, '0, '0, 0, 0, '0);
    // R5 / R6 / R7: alignment with a block offered, then restart at lane 0
    step("R2", 1, 64'hAB, 4'b0000, 0, 0, '0);
    step("R6", 1, 64'hCD, 4'b0000, 0, 1, '0);
    step("R7", 1, 64'hEF, 4'b0000, 0, 0, '0);
    // R3: 10-lane dealing, mode switch with pointer reset rule
    for (int k = 0; k < 14; k++)
      step("R3", 1, 64'h2222_0000_0000_0000 + 64'(k), legal_code(k), 1, 0, '0);
    for (int k = 0; k < 3; k++)
      step("R3", 1, 64'h3333_0000_0000_0000 + 64'(k), 4'b0000, 0, 0, '0);
    // R8 / R9: faulty lanes get nulls, data skips them
    for (int k = 0; k < 8; k++)
      step("R9", 1, 64'h4444_0000_0000_0000 + 64'(k), 4'b0000, 1, 0, 10'b0100100110);
    step("R5", 1, 64'h55, 4'b0000, 1, 1, 10'b0100100110);
    step("R7", 1, 64'h56, 4'b0000, 1, 0, 10'b0000000011);
    // R12: all active lanes faulty
    step("R12", 1, 64'h66, 4'b0000, 0, 0, 10'b0000001111);
    step("R12", 1, 64'h67, 4'b0000, 1, 0, 10'b1111111111);

    // Random mix
    for (int t = 0; t < 400; t++) begin
      bit wide = ($urandom % 8) == 0 ? ~wide_mode : wide_mode;
      bit al = ($urandom % 16) == 0;
      logic [L-1:0] fm = (($urandom % 4) == 0) ? L'($urandom) & L'($urandom) : '0;
      rd = {$urandom, $urandom};
      step(wide ? "R3" : "R2", ($urandom % 4) != 0, rd, legal_code(int'($urandom % 12)),
           wide, al, fm);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule